// File: doc/BRIEF.md
# Vectored Interrupt Address Generator

This block gathers conversion-complete events from five ADC channel pairs and turns them into one interrupt request plus a ready-made jump address. Software loads the start of a jump table into a base register. Each table entry is a four-address slot. Reading the base register back does not return the stored word. It returns the table start plus the slot of the pending pair with the lowest number. An interrupt handler can therefore branch straight to that slot. The slot clears the pair's flag and then branches to the handler for that pair.

The per-pair flags sit in a status register that software can read. Software clears one flag by writing the pair index to a clear-one location, or clears every flag by writing to a clear-all location. The request output is a level. It stays high while any flag is set. If a handler clears one flag while others are still set, the request remains asserted and no event is lost. A hardware event that arrives in the same cycle as a software clear of the same flag wins.

Top module: `vecirq_gen`

## Requirements
- R1: After synchronous reset the stored base is 0, every pair flag is 0, `irq_req` is 0, and a read at select 0 returns 0x0000.
- R2: A read at select 0 (base) returns, modulo 2^16, the stored base with bits [1:0] forced to zero, plus four times the index of the selected pending pair. For example, base 0x0360 gives 0x0364 for pair 1 and 0x036C for pair 3, and base 0xFFF0 with pair 4 wraps to 0x0000.
- R3: When several flags are pending, the pair with the lowest number selects the slot.
- R4: When no flag is pending, a read at select 0 returns the aligned base (offset zero).
- R5: A high `pair_done[n]` at a clock edge sets flag n. A read at select 1 (status) returns flag n in bit n, with bits [15:5] at zero.
- R6: A write at select 2 clears only flag v, where v is the whole 16-bit write value and 0 <= v <= 4. Any other value changes no flag.
- R7: A write at select 3, with any data, clears all flags.
- R8: If `pair_done[n]` is high in the same cycle as a clear of flag n (by select 2 or select 3), flag n ends up set.
- R9: `irq_req` is high exactly while at least one flag is set. It stays high after one flag is cleared while another is still set.
- R10: A write at select 1 changes no flag and does not change the base. A read at select 2 or select 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_sel | input | 2 | Register select: 0 base, 1 status, 2 clear one, 3 clear all |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_sel` |
| pair_done | input | 5 | Per-pair conversion-complete events, one bit per pair |
| irq_req | output | 1 | Level interrupt request to the interrupt controller |

## Verification
The bound checker examines these properties on every cycle:
- Reset clearing.
- Flag setting by an event.
- Single-flag and all-flag clears.
- Priority of an event over a clear in the same cycle.
- Flags holding still when nothing touches them.
- Slot alignment of the composed address.

The bench's scenarios show the arithmetic of the composed address, including the example values and the wrap at the top of the address space. They also cover priority among several pending pairs, the rejection of out-of-range clear indices, and the base and flags staying unchanged after status writes. These are compared against a bench model across directed corners and a long randomized run.

// File: rtl/vecirq_pkg.sv
`timescale 1ns/100ps
package vecirq_pkg;

    parameter int unsigned NUM_PAIRS = 5;
    parameter int unsigned ADDR_W    = 16;
    parameter int unsigned SLOT_LG   = 2;
    localparam int unsigned IDX_W    = $clog2(NUM_PAIRS);

    typedef enum logic [1:0] {
        SEL_BASE    = 2'd0,
        SEL_STATUS  = 2'd1,
        SEL_CLR_ONE = 2'd2,
        SEL_CLR_ALL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } pend_t;

    typedef struct packed {
        logic             clr_one;
        logic             clr_all;
        logic [IDX_W-1:0] clr_idx;
    } clr_cmd_t;

    function automatic pend_t lowest_pending(input logic [NUM_PAIRS-1:0] f);
        pend_t r;
        r = '0;
        for (int i = NUM_PAIRS - 1; i >= 0; i--) begin
            if (f[i]) begin
                r.valid = 1'b1;
                r.idx   = IDX_W'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/vecirq_decode.sv
`timescale 1ns/100ps
module vecirq_decode
    import vecirq_pkg::*;
#(
    parameter int unsigned DATA_W = ADDR_W
) (
    input  logic              bus_wr,
    input  logic [1:0]        bus_sel,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              base_we,
    output clr_cmd_t          clr_cmd
);
    reg_sel_e sel;
    logic     idx_in_range;

    assign sel          = reg_sel_e'(bus_sel);
    assign idx_in_range = (bus_wdata < DATA_W'(NUM_PAIRS));

    always_comb begin
        base_we         = 1'b0;
        clr_cmd         = '0;
        clr_cmd.clr_idx = bus_wdata[IDX_W-1:0];
        if (bus_wr) begin
            unique case (sel)
                SEL_BASE:    base_we         = 1'b1;
                SEL_STATUS:  ;
                SEL_CLR_ONE: clr_cmd.clr_one = idx_in_range;
                SEL_CLR_ALL: clr_cmd.clr_all = 1'b1;
                default:     ;
            endcase
        end
    end
endmodule

// File: rtl/vecirq_flags.sv
`timescale 1ns/100ps
module vecirq_flags
    import vecirq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PAIRS-1:0] set_i,
    input  clr_cmd_t             clr_cmd,
    output logic [NUM_PAIRS-1:0] flag_q
);
    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        logic clr_hit;
        assign clr_hit = clr_cmd.clr_all ||
                         (clr_cmd.clr_one && (clr_cmd.clr_idx == IDX_W'(g)));
        always_ff @(posedge clk) begin
            if (rst)
                flag_q[g] <= 1'b0;
            else
                flag_q[g] <= set_i[g] | (flag_q[g] & ~clr_hit);
        end
    end
endmodule

// File: rtl/vecirq_compose.sv
`timescale 1ns/100ps
module vecirq_compose
    import vecirq_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned SL = SLOT_LG
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           base_we,
    input  logic [AW-1:SL] base_wdata,
    input  pend_t          pend,
    output logic [AW-1:0]  jump_addr
);
    logic [AW-1:SL] base_q;
    logic [AW-1:0]  aligned;
    logic [AW-1:0]  offset;

    always_ff @(posedge clk) begin
        if (rst)
            base_q <= '0;
        else if (base_we)
            base_q <= base_wdata;
    end

    assign aligned   = {base_q, {SL{1'b0}}};
    assign offset    = pend.valid ? (AW'(pend.idx) << SL) : '0;
    assign jump_addr = aligned + offset;
endmodule

// File: rtl/vecirq_gen.sv
`timescale 1ns/100ps
module vecirq_gen
    import vecirq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [1:0]           bus_sel,
    input  logic [ADDR_W-1:0]    bus_wdata,
    output logic [ADDR_W-1:0]    bus_rdata,
    input  logic [NUM_PAIRS-1:0] pair_done,
    output logic                 irq_req
);
    logic                 base_we;
    clr_cmd_t             clr_cmd;
    logic [NUM_PAIRS-1:0] flag_q;
    pend_t                pend;
    logic [ADDR_W-1:0]    jump_addr;

    vecirq_decode #(.DATA_W(ADDR_W)) u_decode (
        .bus_wr    (bus_wr),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .base_we   (base_we),
        .clr_cmd   (clr_cmd)
    );

    vecirq_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (pair_done),
        .clr_cmd (clr_cmd),
        .flag_q  (flag_q)
    );

    assign pend = lowest_pending(flag_q);

    vecirq_compose #(.AW(ADDR_W), .SL(SLOT_LG)) u_compose (
        .clk        (clk),
        .rst        (rst),
        .base_we    (base_we),
        .base_wdata (bus_wdata[ADDR_W-1:SLOT_LG]),
        .pend       (pend),
        .jump_addr  (jump_addr)
    );

    always_comb begin
        unique case (reg_sel_e'(bus_sel))
            SEL_BASE:   bus_rdata = jump_addr;
            SEL_STATUS: bus_rdata = ADDR_W'(flag_q);
            default:    bus_rdata = '0;
        endcase
    end

    assign irq_req = |flag_q;
endmodule

// File: rtl/vecirq_gen_chk.sv
`timescale 1ns/100ps
module vecirq_gen_chk
    import vecirq_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_wr,
    input logic [1:0]           bus_sel,
    input logic [ADDR_W-1:0]    bus_wdata,
    input logic [ADDR_W-1:0]    bus_rdata,
    input logic [NUM_PAIRS-1:0] pair_done,
    input logic                 irq_req,
    input logic [NUM_PAIRS-1:0] flag_q
);
    logic clr_all_wr;
    assign clr_all_wr = bus_wr && (bus_sel == 2'd3);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (flag_q == '0 && !irq_req));

    assert_slot_align_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_sel == 2'd0) |-> (bus_rdata[SLOT_LG-1:0] == '0));

    assert_clr_all_R7: assert property (@(posedge clk) disable iff (rst)
        (clr_all_wr && pair_done == '0) |=> (flag_q == '0));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        clr_all_wr |=> ((flag_q & $past(pair_done)) == $past(pair_done)));

    assert_irq_raise_R9: assert property (@(posedge clk) disable iff (rst)
        (|pair_done) |=> irq_req);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr && pair_done == '0) |=> $stable(flag_q));

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_chk
        assert_set_R5: assert property (@(posedge clk) disable iff (rst)
            pair_done[g] |=> flag_q[g]);

        assert_clr_one_R6: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_sel == 2'd2 && bus_wdata == ADDR_W'(g) && !pair_done[g])
            |=> !flag_q[g]);
    end
endmodule

bind vecirq_gen vecirq_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_sel   (bus_sel),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pair_done (pair_done),
    .irq_req   (irq_req),
    .flag_q    (flag_q)
);

// File: tb/vecirq_gen_test.sv
`timescale 1ns/100ps
module vecirq_gen_test;
    localparam int NP = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_sel = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [NP-1:0] pair_done = '0;
    logic        irq_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [15:0]   m_base  = '0;
    logic [NP-1:0] m_flags = '0;

    vecirq_gen uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pair_done(pair_done), .irq_req(irq_req)
    );

    always #2 clk = ~clk;

    function automatic logic [15:0] exp_jump(input logic [15:0] b, input logic [NP-1:0] f);
        logic [15:0] off;
        off = '0;
        for (int i = NP - 1; i >= 0; i--)
            if (f[i]) off = 16'(i * 4);
        return {b[15:2], 2'b00} + off;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic observe(input string tag);
        bus_wr = 1'b0;
        bus_sel = 2'd0;
        #0.5;
        check({tag, " R2 R3 R4 base read"}, bus_rdata, exp_jump(m_base, m_flags));
        bus_sel = 2'd1;
        #0.5;
        check({tag, " R5 status read"}, bus_rdata, 16'(m_flags));
        check({tag, " R9 irq"}, 16'(irq_req), 16'(m_flags != '0));
    endtask

    task automatic cycle(input logic [NP-1:0] done, input logic wr, input logic [1:0] sel,
                         input logic [15:0] data, input string tag);
        @(negedge clk);
        pair_done = done;
        bus_wr = wr;
        bus_sel = sel;
        bus_wdata = data;
        @(posedge clk);
        #0.5;
        if (wr && sel == 2'd0) m_base = data;
        if (wr && sel == 2'd2 && data < 16'(NP)) m_flags[data[2:0]] = 1'b0;
        if (wr && sel == 2'd3) m_flags = '0;
        m_flags = m_flags | done;
        pair_done = '0;
        observe(tag);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1357_2468));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0.5;
        observe("R1 reset");
        bus_sel = 2'd2;
        #0.5;
        check("R10 read sel2", bus_rdata, 16'h0000);

        // R2 example values
        cycle('0, 1'b1, 2'd0, 16'h0360, "R2 base write");
        cycle(5'b00010, 1'b0, 2'd0, 16'h0, "R2 pair1");
        bus_sel = 2'd0; #0.5; check("R2 0x0364", bus_rdata, 16'h0364);
        cycle(5'b01000, 1'b1, 2'd3, 16'h0, "R8 set during clear-all");
        bus_sel = 2'd0; #0.5; check("R2 0x036C", bus_rdata, 16'h036C);
        // R3 priority
        cycle(5'b10110, 1'b1, 2'd3, 16'h0, "R3 setup");
        bus_sel = 2'd0; #0.5; check("R3 lowest pair 1", bus_rdata, 16'h0364);
        // R9: clear pair 1, others remain -> irq stays
        cycle('0, 1'b1, 2'd2, 16'd1, "R6 clear pair1");
        bus_sel = 2'd0; #0.5; check("R3 next lowest pair 2", bus_rdata, 16'h0368);
        check("R9 irq stays", 16'(irq_req), 16'h1);
        // R6 out-of-range indices
        cycle('0, 1'b1, 2'd2, 16'd5, "R6 index 5 ignored");
        cycle('0, 1'b1, 2'd2, 16'd7, "R6 index 7 ignored");
        cycle('0, 1'b1, 2'd2, 16'h0102, "R6 wide value ignored");
        bus_sel = 2'd1; #0.5; check("R6 flags kept", bus_rdata, 16'h0014);
        // R8 set wins over single clear
        cycle(5'b00100, 1'b1, 2'd2, 16'd2, "R8 set during clear-one");
        bus_sel = 2'd1; #0.5; check("R8 flag2 kept", bus_rdata, 16'h0014);
        // R10 status write ignored
        cycle('0, 1'b1, 2'd1, 16'hFFFF, "R10 status write");
        bus_sel = 2'd1; #0.5; check("R10 flags unchanged", bus_rdata, 16'h0014);
        bus_sel = 2'd3; #0.5; check("R10 read sel3", bus_rdata, 16'h0000);
        // R7 clear all, R4 idle base, alignment
        cycle('0, 1'b1, 2'd3, 16'h1234, "R7 clear all");
        check("R9 irq low", 16'(irq_req), 16'h0);
        cycle('0, 1'b1, 2'd0, 16'h0363, "R4 unaligned base");
        bus_sel = 2'd0; #0.5; check("R4 idle aligned", bus_rdata, 16'h0360);
        // R2 wrap
        cycle('0, 1'b1, 2'd0, 16'hFFF0, "R2 wrap base");
        cycle(5'b10000, 1'b0, 2'd0, 16'h0, "R2 wrap pair4");
        bus_sel = 2'd0; #0.5; check("R2 wrap 0x0000", bus_rdata, 16'h0000);

        // randomized run
        for (int k = 0; k < 3000; k++) begin
            logic [NP-1:0] d;
            logic [15:0] w;
            logic [1:0] s;
            d = ($urandom % 4 == 0) ? NP'($urandom) : '0;
            s = 2'($urandom);
            w = ($urandom % 2 == 0) ? 16'($urandom % 8) : 16'($urandom);
            cycle(d, ($urandom % 3 == 0), s, w, "rand");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule